// File: doc/BRIEF.md
# Four-Lane ADC DC Offset Corrector

This block removes the DC bias from four parallel signed ADC sample lanes before the samples reach later processing. Lane 0 is the I branch of receive side A, lane 1 its Q branch, lane 2 the I branch of receive side B, and lane 3 its Q branch. Each lane has two ways to remove the bias:

- a software-programmed manual offset;
- an automatic tracking loop that follows the lane's mean and subtracts it.

A bits/mask pair switches the tracking loop on or off for each lane. A write changes only the lanes whose mask bit is set. After reset every loop is on.

Samples move in and out over a valid/ready stream. All four lanes share one handshake. An accepted sample set appears on the output one clock later, held in a single register stage. When the consumer holds `out_ready` low, that stage keeps its data and `in_ready` drops. Upstream must then hold its sample until `in_ready` returns. The offset and enable pins are plain write strobes with no handshake.

Top module: `dcoc_top`

## Requirements
- R1: After reset `out_valid` is 0, all four loop enables are 1, every tracking estimate is 0 and every manual offset is 0.
- R2: Lane n of `in_data` and `out_data` occupies bits [16n+15:16n]. Lanes 0..3 are side A I, side A Q, side B I and side B Q. Each lane is processed only with its own offset, estimate and enable.
- R3: `in_ready` is high when the output stage is empty or `out_ready` is high. A sample set accepted on a clock edge (`in_valid` and `in_ready` both high) is presented on `out_data` with `out_valid` high after that edge. `out_valid` falls after an edge where the output was taken and nothing new was accepted.
- R4: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold, and no input is accepted. A sample offered during that stall does not affect any lane's estimate.
- R5: A clock edge with `ofs_we` high loads `ofs_val` (signed 16-bit) into the manual offset of lane `ofs_sel`. The new offset applies to samples accepted after that edge.
- R6: A clock edge with `en_we` high sets enable n to `en_bits[n]` for every n with `en_mask[n]` high. Enables whose mask bit is 0 keep their value. A mask of 0 changes nothing.
- R7: With its loop on, a lane outputs x - floor(E / 2^16). E is a signed estimate with 16 fractional bits. E is then updated as E += (x*2^16 - E) >>> SHIFT (arithmetic shift), once per accepted sample.
- R8: With its loop off, a lane outputs x minus its manual offset, and its estimate stays frozen. When the loop is turned back on, tracking resumes from the frozen value.
- R9: Every subtraction saturates to [-32768, 32767] instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample set valid |
| in_ready | output | 1 | Block can accept a sample set |
| in_data | input | 64 | Four signed 16-bit raw samples |
| out_valid | output | 1 | Corrected sample set valid |
| out_ready | input | 1 | Consumer takes the output |
| out_data | output | 64 | Four signed 16-bit corrected samples |
| ofs_we | input | 1 | Manual offset write strobe |
| ofs_sel | input | 2 | Lane whose offset is written |
| ofs_val | input | 16 | Signed manual offset value |
| en_we | input | 1 | Loop enable write strobe |
| en_bits | input | 4 | New enable values |
| en_mask | input | 4 | Which enables the write changes |

## Verification
The bench builds the block with SHIFT = 2 instead of the default 12. At SHIFT = 2 each estimate moves a quarter of the way to the input per sample, so the tracked output changes visibly within a handful of samples. The bench can therefore follow convergence, a freeze and a resumption of tracking against its own fixed-point model in a few dozen cycles. Lane width, lane count and fraction width stay at their defaults, so the saturation corners land on the real 16-bit limits.

// File: rtl/dcoc_pkg.sv
package dcoc_pkg;
  // Default geometry of the corrector
  localparam int DCOC_DW    = 16;  // sample width
  localparam int DCOC_NCH   = 4;   // lanes
  localparam int DCOC_FRAC  = 16;  // fractional bits of the estimate
  localparam int DCOC_SHIFT = 12;  // loop gain as a right shift
endpackage

// File: rtl/dcoc_ctrl.sv
module dcoc_ctrl #(
  parameter int NCH = dcoc_pkg::DCOC_NCH,
  parameter int DW  = dcoc_pkg::DCOC_DW,
  parameter int SW  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ofs_we,
  input  logic [SW-1:0]     ofs_sel,
  input  logic [DW-1:0]     ofs_val,
  input  logic              en_we,
  input  logic [NCH-1:0]    en_bits,
  input  logic [NCH-1:0]    en_mask,
  output logic [NCH-1:0]    loop_en,
  output logic [NCH*DW-1:0] ofs_flat
);
  // Loop enables: masked update, all on after reset
  always_ff @(posedge clk) begin
    if (rst)        loop_en <= '1;
    else if (en_we) loop_en <= (loop_en & ~en_mask) | (en_bits & en_mask);
  end

  // One manual offset register per lane
  for (genvar i = 0; i < NCH; i++) begin : g_ofs
    always_ff @(posedge clk) begin
      if (rst)
        ofs_flat[i*DW +: DW] <= '0;
      else if (ofs_we && (ofs_sel == SW'(i)))
        ofs_flat[i*DW +: DW] <= ofs_val;
    end
  end

  // R6
  en_mask_chk: assert property (@(posedge clk) disable iff (rst)
    en_we |=> ((loop_en ^ $past(loop_en)) & ~$past(en_mask)) == '0);
  // R6
  en_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en_we |=> $stable(loop_en));
endmodule

// File: rtl/dcoc_lane.sv
module dcoc_lane #(
  parameter int DW    = dcoc_pkg::DCOC_DW,
  parameter int FRAC  = dcoc_pkg::DCOC_FRAC,
  parameter int SHIFT = dcoc_pkg::DCOC_SHIFT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          loop_on,
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] ofs,
  output logic [DW-1:0] y
);
  localparam int EW = DW + FRAC;
  localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic signed [EW-1:0] est_q;
  logic signed [EW:0]   diff, step;
  logic        [DW-1:0] sub;
  logic signed [DW:0]   full;

  // Tracking update: move the estimate a 2^-SHIFT fraction toward x
  always_comb begin
    diff = $signed({x[DW-1], x, {FRAC{1'b0}}}) - $signed({est_q[EW-1], est_q});
    step = diff >>> SHIFT;
  end

  always_ff @(posedge clk) begin
    if (rst)                 est_q <= '0;
    else if (take && loop_on) est_q <= est_q + $signed(step[EW-1:0]);
  end

  // Subtract either the tracked integer part or the manual offset, saturating
  always_comb begin
    sub  = loop_on ? est_q[EW-1:FRAC] : ofs;
    full = $signed({x[DW-1], x}) - $signed({sub[DW-1], sub});
    if (full[DW] != full[DW-1]) y = full[DW] ? MINV : MAXV;
    else                        y = full[DW-1:0];
  end

  // R8
  frozen_est_chk: assert property (@(posedge clk) disable iff (rst)
    !loop_on |=> $stable(est_q));
endmodule

// File: rtl/dcoc_top.sv
module dcoc_top #(
  parameter int NCH   = dcoc_pkg::DCOC_NCH,
  parameter int DW    = dcoc_pkg::DCOC_DW,
  parameter int FRAC  = dcoc_pkg::DCOC_FRAC,
  parameter int SHIFT = dcoc_pkg::DCOC_SHIFT,
  localparam int SW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [NCH*DW-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NCH*DW-1:0] out_data,
  input  logic              ofs_we,
  input  logic [SW-1:0]     ofs_sel,
  input  logic [DW-1:0]     ofs_val,
  input  logic              en_we,
  input  logic [NCH-1:0]    en_bits,
  input  logic [NCH-1:0]    en_mask
);
  logic [NCH-1:0]    loop_en;
  logic [NCH*DW-1:0] ofs_flat;
  logic [NCH*DW-1:0] y_flat;
  logic              accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  dcoc_ctrl #(.NCH(NCH), .DW(DW), .SW(SW)) u_ctrl (
    .clk(clk), .rst(rst),
    .ofs_we(ofs_we), .ofs_sel(ofs_sel), .ofs_val(ofs_val),
    .en_we(en_we), .en_bits(en_bits), .en_mask(en_mask),
    .loop_en(loop_en), .ofs_flat(ofs_flat)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    dcoc_lane #(.DW(DW), .FRAC(FRAC), .SHIFT(SHIFT)) u_lane (
      .clk(clk), .rst(rst), .take(accept), .loop_on(loop_en[i]),
      .x(in_data[i*DW +: DW]), .ofs(ofs_flat[i*DW +: DW]),
      .y(y_flat[i*DW +: DW])
    );
  end

  // Single output stage
  always_ff @(posedge clk) begin
    if (rst)           out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (rst)         out_data <= '0;
    else if (accept) out_data <= y_flat;
  end

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R3
  accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);
  // R3
  drain_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !in_valid |=> !out_valid);
endmodule

// File: tb/sim_dcoc_top.sv
module sim_dcoc_top;
  localparam int NCH = 4, DW = 16, SHIFT = 2;

  logic clk = 0, rst = 1;
  logic in_valid = 0, out_ready = 1, ofs_we = 0, en_we = 0;
  logic in_ready, out_valid;
  logic [63:0] in_data = '0;
  logic [63:0] out_data;
  logic [1:0]  ofs_sel = '0;
  logic [15:0] ofs_val = '0;
  logic [3:0]  en_bits = '0, en_mask = '0;

  int errors = 0, checks = 0;
  bit done = 0;

  // bench model
  longint est[4];
  bit     en[4];
  int     ofs[4];

  always #5 clk = ~clk;

  dcoc_top #(.SHIFT(SHIFT)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .ofs_we(ofs_we), .ofs_sel(ofs_sel),
    .ofs_val(ofs_val), .en_we(en_we), .en_bits(en_bits), .en_mask(en_mask)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  // expected output for lane ch, and model update
  function automatic int model(int ch, int x);
    longint s;
    int r;
    s = en[ch] ? (est[ch] >>> 16) : longint'(ofs[ch]);
    r = sat(longint'(x) - s);
    if (en[ch]) est[ch] = est[ch] + (((longint'(x) <<< 16) - est[ch]) >>> SHIFT);
    return r;
  endfunction

  // Send one sample set and compare all lanes one cycle later
  task automatic send(string req, int x0, int x1, int x2, int x3);
    int xs[4];
    int ex[4];
    xs = '{x0, x1, x2, x3};
    @(negedge clk);
    for (int i = 0; i < 4; i++) in_data[i*16 +: 16] = 16'(xs[i]);
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    for (int i = 0; i < 4; i++) ex[i] = model(i, xs[i]);
    check({req, " R3 valid"}, out_valid, 1);
    for (int i = 0; i < 4; i++)
      check({req, " R2 lane"}, longint'($signed(out_data[i*16 +: 16])), ex[i]);
  endtask

  task automatic write_en(logic [3:0] b, logic [3:0] m);
    @(negedge clk);
    en_we = 1; en_bits = b; en_mask = m;
    @(negedge clk);
    en_we = 0;
    for (int i = 0; i < 4; i++) if (m[i]) en[i] = b[i];
  endtask

  task automatic write_ofs(int ch, int v);
    @(negedge clk);
    ofs_we = 1; ofs_sel = 2'(ch); ofs_val = 16'(v);
    @(negedge clk);
    ofs_we = 0;
    ofs[ch] = v;
  endtask

  task automatic t_reset();
    check("R1 out_valid", out_valid, 0);
    check("R3 in_ready", in_ready, 1);
    // estimate 0 and loop on: first samples pass through unchanged
    send("R1", 1234, -77, 0, 32767);
    @(negedge clk);
    check("R3 drain", out_valid, 0);
  endtask

  task automatic t_track();
    // R7: constant and varying inputs converge through the loop
    for (int k = 0; k < 6; k++) send("R7 const", 4000, -3000, 200, -1);
    for (int k = 0; k < 4; k++) send("R7 step", -100 * k, 50 + k, 7000, -20000);
  endtask

  task automatic t_mask();
    write_en(4'b0000, 4'b0000);    // R6 mask zero: nothing changes
    send("R6 nomask", 10, 20, 30, 40);
    write_en(4'b0101, 4'b0010);    // R6 only lane 1 changes (turns on already on -> off? bit1=0)
    write_ofs(1, 25);
    send("R6 lane1 off", 100, 100, 100, 100);
  endtask

  task automatic t_freeze();
    write_en(4'b0000, 4'b0001);    // R8 freeze lane 0
    write_ofs(0, 0);
    for (int k = 0; k < 3; k++) send("R8 frozen", 9000, 1, 2, 3);
    write_en(4'b0001, 4'b0001);    // R8 resume from frozen estimate
    for (int k = 0; k < 3; k++) send("R8 resume", 4000, 1, 2, 3);
  endtask

  task automatic t_manual();
    write_en(4'b0000, 4'b1111);
    write_ofs(2, -500);
    write_ofs(3, 1234);
    send("R5 manual", 0, 0, 100, 100);
    send("R5 manual2", -1, 5, -32000, 2000);
  endtask

  task automatic t_sat();
    write_ofs(0, -32768);
    write_ofs(1, 32767);
    write_ofs(2, 100);
    send("R9 sat", 32767, -32768, -50, 0);
    write_en(4'b1111, 4'b1111);
    send("R9 loop", 32767, -32768, 32767, -32768);
  endtask

  task automatic t_backpressure();
    int held;
    @(negedge clk);
    out_ready = 0;
    in_data = {16'(3), 16'(2), 16'(1), 16'(500)};
    in_valid = 1;
    held = model(0, 500);
    void'(model(1, 1)); void'(model(2, 2)); void'(model(3, 3));
    @(negedge clk);
    in_data = {16'(-9000), 16'(-9000), 16'(-9000), 16'(-9000)};
    check("R4 valid", out_valid, 1);
    check("R4 in_ready low", in_ready, 0);
    @(negedge clk);
    check("R4 hold", longint'($signed(out_data[15:0])), held);
    check("R4 in_ready low2", in_ready, 0);
    in_valid = 0;
    out_ready = 1;
    @(negedge clk);
    check("R3 drain", out_valid, 0);
    // stalled offer must not have moved any estimate
    send("R4 est untouched", 500, 1, 2, 3);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin est[i] = 0; en[i] = 1; ofs[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_track();
    t_mask();
    t_freeze();
    t_manual();
    t_sat();
    t_backpressure();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule